// File: doc/BRIEF.md
# UART FIFO Block-Transfer Ready Pins

This block drives the two active-low request pins of a UART with 64-entry transmit and receive FIFOs. A companion data path or an external transfer engine watches these pins to decide when to move characters. The block follows each FIFO's fill level with its own counter. The counters advance on the push and pop strobes that the FIFO logic already produces. The pins are then derived from those counts and the two control bits: FIFO enable and block-transfer mode.

With the FIFOs off, the pins reflect two single-character holding-register flags. With the FIFOs on and block mode off, the receive pin asks for service whenever any byte is waiting. The transmit pin asks only when the transmit FIFO has fully drained.

In block mode the rules change:
- The receive pin requests service once the fill level reaches a programmable trigger, or when a receive time-out strobe arrives. It then stays asserted until the receive FIFO is completely empty, so a whole block can be unloaded in one burst.
- The transmit pin requests service whenever at least one free location remains.

Top module: `uart_ready_pins`

## Requirements
- R1: While reset is asserted, and on the first clock after it, both rxReadyN and txReadyN are high.
- R2: Each occupancy count spans 0 to 64. A push alone adds one and a pop alone removes one. A push and a pop in the same cycle leave the count unchanged. A lone push at 64 and a lone pop at 0 are ignored.
- R3: With fifoEnable low, rxReadyN is low exactly when holdRxFull is high.
- R4: With fifoEnable low, txReadyN is low exactly when holdTxFull is low.
- R5: With fifoEnable high and blockMode low, rxReadyN is low exactly when the receive count is nonzero.
- R6: With fifoEnable high and blockMode low, txReadyN is low exactly when the transmit count is zero.
- R7: With fifoEnable and blockMode high, rxReadyN goes low once the receive count is nonzero and at least rxTrigLevel.
- R8: With fifoEnable and blockMode high, a pulse on rxTimeout drives rxReadyN low while the receive count is nonzero, even below the trigger.
- R9: With fifoEnable and blockMode high, rxReadyN returns high only when the receive count reaches zero. It stays low while the count is between zero and the trigger.
- R10: With fifoEnable and blockMode high, txReadyN is high exactly when the transmit count is 64.
- R11: With fifoEnable low, blockMode has no effect on either pin.
- R12: Each pin is registered. It shows the effect of a strobe, flag or control change at the clock edge that samples that input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| fifoEnable | input | 1 | FIFO operation enable |
| blockMode | input | 1 | Block-transfer mode select; has an effect only with FIFOs on |
| rxTrigLevel | input | 7 | Receive trigger level, 0 to 64 |
| rxTimeout | input | 1 | Receive time-out strobe |
| rxPush | input | 1 | A byte enters the receive FIFO |
| rxPop | input | 1 | A byte leaves the receive FIFO |
| txPush | input | 1 | A byte enters the transmit FIFO |
| txPop | input | 1 | A byte leaves the transmit FIFO |
| holdRxFull | input | 1 | Receive holding register holds a byte (FIFOs off) |
| holdTxFull | input | 1 | Transmit holding register holds a byte (FIFOs off) |
| rxReadyN | output | 1 | Active-low receive request |
| txReadyN | output | 1 | Active-low transmit request |

## Verification
The hardest state to reach is the receive hysteresis window. Here the receive pin is already asserted, yet the count sits strictly between zero and the trigger. Reaching it needs a fill past the trigger followed by a partial drain. It can also be reached by a time-out on a short FIFO, with more pops afterwards. The stimulus does both. It also fills the transmit counter to 64 and pushes past it, and it issues simultaneous push and pop at both ends of the count range. A behavioural reference model, compared on every clock, confirms that the pins move on exactly the right cycle.

// File: rtl/ready_pkg.sv
package ready_pkg;
  // Qualified counter strobes sent from control to the occupancy datapath.
  typedef struct packed {
    logic rxInc;
    logic rxDec;
    logic txInc;
    logic txDec;
  } cntStrobe_t;
endpackage

// File: rtl/ready_datapath.sv
module ready_datapath
  import ready_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  cntStrobe_t    stb,
  output logic [CW-1:0] rxCount,
  output logic [CW-1:0] txCount,
  output logic [CW-1:0] rxNext,
  output logic [CW-1:0] txNext
);
  localparam int NCNT = 2;

  logic [NCNT-1:0]         incVec;
  logic [NCNT-1:0]         decVec;
  logic [NCNT-1:0][CW-1:0] cntQ;
  logic [NCNT-1:0][CW-1:0] cntD;

  assign incVec = {stb.txInc, stb.rxInc};
  assign decVec = {stb.txDec, stb.rxDec};

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    always_comb begin
      cntD[g] = cntQ[g];
      if (incVec[g])      cntD[g] = cntQ[g] + CW'(1);
      else if (decVec[g]) cntD[g] = cntQ[g] - CW'(1);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) cntQ[g] <= '0;
      else       cntQ[g] <= cntD[g];
    end

    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
      cntQ[g] <= CW'(DEPTH));

    a_r2_single_step: assert property (@(posedge clk) disable iff (!rstN)
      (cntQ[g] != $past(cntQ[g])) |->
        ((cntQ[g] == $past(cntQ[g]) + CW'(1)) || (cntQ[g] == $past(cntQ[g]) - CW'(1))));
  end

  assign rxCount = cntQ[0];
  assign txCount = cntQ[1];
  assign rxNext  = cntD[0];
  assign txNext  = cntD[1];
endmodule

// File: rtl/ready_control.sv
module ready_control
  import ready_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          fifoEnable,
  input  logic          blockMode,
  input  logic [CW-1:0] rxTrigLevel,
  input  logic          rxTimeout,
  input  logic          rxPush,
  input  logic          rxPop,
  input  logic          txPush,
  input  logic          txPop,
  input  logic          holdRxFull,
  input  logic          holdTxFull,
  input  logic [CW-1:0] rxCount,
  input  logic [CW-1:0] txCount,
  input  logic [CW-1:0] rxNext,
  input  logic [CW-1:0] txNext,
  output cntStrobe_t    stb,
  output logic          rxReadyN,
  output logic          txReadyN
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic rxPinD;
  logic txPinD;
  logic blockOn;

  // Push and pop together cancel; lone push at full or lone pop at empty dropped.
  always_comb begin
    stb.rxInc = rxPush && !rxPop && (rxCount != FULL);
    stb.rxDec = rxPop && !rxPush && (rxCount != '0);
    stb.txInc = txPush && !txPop && (txCount != FULL);
    stb.txDec = txPop && !txPush && (txCount != '0);
  end

  assign blockOn = fifoEnable && blockMode;

  always_comb begin
    if (!fifoEnable)             rxPinD = !holdRxFull;
    else if (!blockMode)         rxPinD = (rxNext == '0);
    else if (rxNext == '0)       rxPinD = 1'b1;
    else if ((rxNext >= rxTrigLevel) || rxTimeout) rxPinD = 1'b0;
    else                         rxPinD = rxReadyN;
  end

  always_comb begin
    if (!fifoEnable)     txPinD = holdTxFull;
    else if (!blockMode) txPinD = (txNext != '0);
    else                 txPinD = (txNext == FULL);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxReadyN <= 1'b1;
      txReadyN <= 1'b1;
    end else begin
      rxReadyN <= rxPinD;
      txReadyN <= txPinD;
    end
  end

  a_r9_release_only_empty: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rxReadyN) && $past(rstN) && $past(blockOn)) |-> (rxCount == '0));

  a_r7_reach_trigger: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(blockOn) && (rxCount != '0) && (rxCount >= $past(rxTrigLevel)))
      |-> !rxReadyN);

  a_r10_tx_full_rule: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(blockOn)) |-> (txReadyN == (txCount == FULL)));

  a_r6_tx_empty_rule: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(fifoEnable) && !$past(blockMode)) |-> (txReadyN == (txCount != '0)));

  a_r5_rx_any_rule: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(fifoEnable) && !$past(blockMode)) |-> (rxReadyN == (rxCount == '0)));
endmodule

// File: rtl/uart_ready_pins.sv
module uart_ready_pins
  import ready_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          fifoEnable,
  input  logic          blockMode,
  input  logic [CW-1:0] rxTrigLevel,
  input  logic          rxTimeout,
  input  logic          rxPush,
  input  logic          rxPop,
  input  logic          txPush,
  input  logic          txPop,
  input  logic          holdRxFull,
  input  logic          holdTxFull,
  output logic          rxReadyN,
  output logic          txReadyN
);
  cntStrobe_t    stb;
  logic [CW-1:0] rxCount;
  logic [CW-1:0] txCount;
  logic [CW-1:0] rxNext;
  logic [CW-1:0] txNext;

  ready_control #(.DEPTH(DEPTH), .CW(CW)) i_ctrl (
    .clk(clk), .rstN(rstN), .fifoEnable(fifoEnable), .blockMode(blockMode),
    .rxTrigLevel(rxTrigLevel), .rxTimeout(rxTimeout),
    .rxPush(rxPush), .rxPop(rxPop), .txPush(txPush), .txPop(txPop),
    .holdRxFull(holdRxFull), .holdTxFull(holdTxFull),
    .rxCount(rxCount), .txCount(txCount), .rxNext(rxNext), .txNext(txNext),
    .stb(stb), .rxReadyN(rxReadyN), .txReadyN(txReadyN)
  );

  ready_datapath #(.DEPTH(DEPTH), .CW(CW)) i_data (
    .clk(clk), .rstN(rstN), .stb(stb),
    .rxCount(rxCount), .txCount(txCount), .rxNext(rxNext), .txNext(txNext)
  );
endmodule

// File: tb/test_uart_ready_pins.sv
module test_uart_ready_pins;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fifoEnable = 1'b0, blockMode = 1'b0;
  logic [6:0] rxTrigLevel = 7'd1;
  logic rxTimeout = 1'b0, rxPush = 1'b0, rxPop = 1'b0, txPush = 1'b0, txPop = 1'b0;
  logic holdRxFull = 1'b0, holdTxFull = 1'b0;
  logic rxReadyN, txReadyN;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_ready_pins i_uart_ready_pins (
    .clk(clk), .rstN(rstN), .fifoEnable(fifoEnable), .blockMode(blockMode),
    .rxTrigLevel(rxTrigLevel), .rxTimeout(rxTimeout),
    .rxPush(rxPush), .rxPop(rxPop), .txPush(txPush), .txPop(txPop),
    .holdRxFull(holdRxFull), .holdTxFull(holdTxFull),
    .rxReadyN(rxReadyN), .txReadyN(txReadyN)
  );

  // Behavioural reference model.
  int    mRx = 0, mTx = 0;
  logic  mRxN = 1'b1, mTxN = 1'b1;
  string mRxTag = "R1", mTxTag = "R1";

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mRx <= 0; mTx <= 0; mRxN <= 1'b1; mTxN <= 1'b1; mRxTag <= "R1"; mTxTag <= "R1";
    end else begin
      int nr, nt;
      nr = mRx; nt = mTx;
      if (rxPush && !rxPop && nr < DEPTH) nr++;
      if (rxPop && !rxPush && nr > 0) nr--;
      if (txPush && !txPop && nt < DEPTH) nt++;
      if (txPop && !txPush && nt > 0) nt--;
      mRx <= nr; mTx <= nt;
      if (!fifoEnable) begin
        mRxN <= !holdRxFull; mTxN <= holdTxFull; mRxTag <= "R3"; mTxTag <= "R4";
      end else if (!blockMode) begin
        mRxN <= (nr == 0); mTxN <= (nt != 0); mRxTag <= "R5"; mTxTag <= "R6";
      end else begin
        if (nr == 0) mRxN <= 1'b1;
        else if (nr >= int'(rxTrigLevel) || rxTimeout) mRxN <= 1'b0;
        mTxN <= (nt == DEPTH); mRxTag <= "R9"; mTxTag <= "R10";
      end
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // Compare on every falling edge.
  always @(negedge clk) begin
    cycles++;
    chk(mRxTag, rxReadyN, mRxN);
    chk(mTxTag, txReadyN, mTxN);
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic cyc(input logic rp, input logic rq, input logic tp, input logic tq, input logic to);
    rxPush = rp; rxPop = rq; txPush = tp; txPop = tq; rxTimeout = to;
    @(negedge clk);
    rxPush = 0; rxPop = 0; txPush = 0; txPop = 0; rxTimeout = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", rxReadyN, 1'b1);
    chk("R1", txReadyN, 1'b1);
    rstN = 1'b1;
    @(negedge clk);
    // R3/R4/R11: FIFOs off, blockMode toggled has no effect.
    blockMode = 1'b1; holdRxFull = 1'b1; holdTxFull = 1'b0;
    @(negedge clk);
    chk("R11", rxReadyN, 1'b0);
    chk("R11", txReadyN, 1'b0);
    holdRxFull = 1'b0; holdTxFull = 1'b1;
    @(negedge clk);
    chk("R3", rxReadyN, 1'b1);
    chk("R4", txReadyN, 1'b1);
    blockMode = 1'b0; holdTxFull = 1'b0;
    // R5/R6/R12: FIFO mode, single push seen one clock later.
    fifoEnable = 1'b1;
    @(negedge clk);
    cyc(1, 0, 1, 0, 0);
    chk("R12", rxReadyN, 1'b0);
    chk("R6", txReadyN, 1'b1);
    cyc(0, 1, 0, 1, 0);
    chk("R5", rxReadyN, 1'b1);
    chk("R6", txReadyN, 1'b0);
    // R2: simultaneous push/pop at empty leaves count zero.
    cyc(1, 1, 1, 1, 0);
    chk("R2", rxReadyN, 1'b1);
    chk("R2", txReadyN, 1'b0);
    // R2/R10: overfill transmit in block mode.
    blockMode = 1'b1;
    for (int i = 0; i < 70; i++) cyc(0, 0, 1, 0, 0);
    chk("R10", txReadyN, 1'b1);
    cyc(0, 0, 1, 1, 0);
    chk("R2", txReadyN, 1'b1);
    cyc(0, 0, 0, 1, 0);
    chk("R10", txReadyN, 1'b0);
    blockMode = 1'b0;
    for (int i = 0; i < 62; i++) cyc(0, 0, 0, 1, 0);
    chk("R2", txReadyN, 1'b1);
    cyc(0, 0, 0, 1, 0);
    chk("R2", txReadyN, 1'b0);
    cyc(0, 0, 0, 1, 0);
    chk("R2", txReadyN, 1'b0);
    // R7/R9: block receive hysteresis with trigger 8.
    blockMode = 1'b1; rxTrigLevel = 7'd8;
    for (int i = 0; i < 7; i++) cyc(1, 0, 0, 0, 0);
    chk("R7", rxReadyN, 1'b1);
    cyc(1, 0, 0, 0, 0);
    chk("R7", rxReadyN, 1'b0);
    for (int i = 0; i < 7; i++) cyc(0, 1, 0, 0, 0);
    chk("R9", rxReadyN, 1'b0);
    cyc(0, 1, 0, 0, 0);
    chk("R9", rxReadyN, 1'b1);
    // R8: time-out below trigger.
    rxTrigLevel = 7'd32;
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 0);
    chk("R8", rxReadyN, 1'b1);
    cyc(0, 0, 0, 0, 1);
    chk("R8", rxReadyN, 1'b0);
    cyc(0, 1, 0, 0, 0);
    chk("R9", rxReadyN, 1'b0);
    cyc(1, 1, 0, 0, 0);
    chk("R9", rxReadyN, 1'b0);
    cyc(0, 1, 0, 0, 0);
    cyc(0, 1, 0, 0, 0);
    chk("R9", rxReadyN, 1'b1);
    // Time-out with empty FIFO leaves pin high.
    cyc(0, 0, 0, 0, 1);
    chk("R8", rxReadyN, 1'b1);
    // Fill receive to 64 and beyond, mixed traffic.
    for (int i = 0; i < 66; i++) cyc(1, 0, (i % 3) == 0, (i % 5) == 0, 0);
    cyc(1, 1, 0, 0, 0);
    for (int i = 0; i < 64; i++) cyc(0, 1, 0, 0, 0);
    chk("R9", rxReadyN, 1'b1);
    repeat (2) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule